// File: doc/BRIEF.md
# Strobed Output Port Pair with Acknowledge Handshake

This block drives bytes written by a CPU out to a peripheral through two independent 8-bit output ports, A and B. Each port keeps an output register and a buffer-full flag, and it has an active-high interrupt line. When a CPU write to a port completes, the port captures the byte and pulls its active-low buffer-full line low. The peripheral answers by pulling its active-low acknowledge line low, and that acknowledge empties the buffer. Once the acknowledge is released and the buffer is empty, the port can interrupt the CPU to ask for the next byte.

Each port has its own interrupt-enable bit. The CPU sets or clears an enable bit with a single bit set/reset command, which names a bit index and a value. Index 6 controls port A and index 2 controls port B. The write strobes are synchronous to the system clock, and the block finds their edges in that clock domain. The acknowledge inputs come from the peripheral clock domain, so each one passes through a two-flop synchronizer first. A peripheral should latch the data on the rising edge of buffer-full, when the data is certain to be valid.

Top module: `strobed_out_pair`

## Requirements
- R1: After reset both buffer-full lines are high, both interrupts are low, both data outputs are 0x00 and both enable bits are clear.
- R2: On the clock edge that samples a rising edge of a port's write strobe (the strobe was low at the previous edge and is high now), the port loads `cpu_din` into its data output and drives its buffer-full line low.
- R3: A port's data output changes only on a write completion to that port. It holds its value while acknowledge is asserted and after it is released.
- R4: The acknowledge input passes through two synchronizer flops. Buffer-full goes high on the third rising clock edge after acknowledge goes low. If a write completion and a synchronized low acknowledge arrive in the same cycle, the write wins, and the buffer empties one cycle later.
- R5: The interrupt goes high on the clock edge after a cycle in which all of these hold: the enable bit is set, the synchronized acknowledge is high, the buffer is empty, and the write strobe has been high at both the current and the previous edge.
- R6: On the clock edge that samples a falling edge of a port's write strobe, the port's interrupt goes low.
- R7: A bit set/reset command (`bsr_we` high for one cycle) with index 6 writes `bsr_val` into port A's enable bit. Index 2 writes it into port B's enable bit. Any other index changes neither bit.
- R8: When a port's enable bit is clear, its interrupt is low from the next clock edge on.
- R9: The two ports are independent. A write or acknowledge on one port leaves the other port's data, buffer-full line and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_din | input | 8 | Byte from the CPU, shared by both ports |
| wr_a_n | input | 1 | Write strobe for port A, active low, synchronous |
| wr_b_n | input | 1 | Write strobe for port B, active low, synchronous |
| bsr_we | input | 1 | Bit set/reset command valid |
| bsr_sel | input | 3 | Bit index of the command (6 = A enable, 2 = B enable) |
| bsr_val | input | 1 | Value to write into the selected bit |
| ack_a_n | input | 1 | Peripheral acknowledge for port A, active low, asynchronous |
| ack_b_n | input | 1 | Peripheral acknowledge for port B, active low, asynchronous |
| pa_dout | output | 8 | Port A data to the peripheral |
| pb_dout | output | 8 | Port B data to the peripheral |
| obf_a_n | output | 1 | Port A buffer full, active low |
| obf_b_n | output | 1 | Port B buffer full, active low |
| intr_a | output | 1 | Port A interrupt request, active high |
| intr_b | output | 1 | Port B interrupt request, active high |

## Verification
The assertions check four relations on every cycle, each against the strobe-edge and synchronized-acknowledge wires. Buffer-full must assert after a write completion, and it must release under a synchronized acknowledge when no write completes. The interrupt must set or clear as its events require. The data must stay stable when no write completes, and an enable bit must not move under a bit set/reset command with an unrelated index. Three things only the bench's scenarios can show. One is the exact latency through the synchronizer, measured from the acknowledge pin. Another is the write-wins ordering when a write completes while acknowledge is held low. The last is that one port is isolated from traffic on the other.

// File: rtl/strobed_out_pkg.sv
package strobed_out_pkg;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 3;
  localparam int N_PORTS  = 2;
  localparam int SYNC_LEN = 2;
  localparam int ENA_IDX_A = 6;
  localparam int ENA_IDX_B = 2;

  // Bit index of the enable bit for a given port number
  function automatic int enable_index(input int port);
    return (port == 0) ? ENA_IDX_A : ENA_IDX_B;
  endfunction

  // Buffer-full flag update: a completed write wins over acknowledge
  function automatic logic full_next(input logic cur, input logic load,
                                     input logic ack_low);
    if (load)         return 1'b1;
    else if (ack_low) return 1'b0;
    else              return cur;
  endfunction

  // Interrupt flag update: disable, then strobe fall, then set condition
  function automatic logic irq_next(input logic cur, input logic en,
                                    input logic clr, input logic set);
    if (!en)      return 1'b0;
    else if (clr) return 1'b0;
    else if (set) return 1'b1;
    else          return cur;
  endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int  STAGES = 2,
  parameter bit  INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] flops;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flops[s] <= INIT;
        else if (s == 0) flops[s] <= d_in;
        else flops[s] <= flops[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_out = flops[STAGES-1];
endmodule

// File: rtl/strobe_edges.sv
module strobe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic ended,
  output logic started,
  output logic idle
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign ended   = ~prev_q &  strobe_n;
  assign started =  prev_q & ~strobe_n;
  assign idle    =  prev_q &  strobe_n;
endmodule

// File: rtl/bsr_enable_bank.sv
module bsr_enable_bank
  import strobed_out_pkg::*;
#(
  parameter int NP = N_PORTS,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [SW-1:0] cmd_sel,
  input  logic          cmd_val,
  output logic [NP-1:0] enables
);
  logic [NP-1:0] hit;

  genvar p;
  generate
    for (p = 0; p < NP; p++) begin : g_bit
      assign hit[p] = cmd_we && (cmd_sel == SW'(enable_index(p)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      enables[p] <= 1'b0;
        else if (hit[p]) enables[p] <= cmd_val;
      end
    end
  endgenerate

  // R7
  foreign_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && hit == '0) |=> $stable(enables));
endmodule

// File: rtl/hs_out_port.sv
module hs_out_port
  import strobed_out_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int SL = SYNC_LEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         wr_n,
  input  logic         ack_n,
  input  logic         irq_en,
  output logic [W-1:0] dout,
  output logic         full_n,
  output logic         irq
);
  logic ack_s;
  logic wr_end, wr_start, wr_idle;
  logic full_q, irq_q;
  logic [W-1:0] data_q;
  logic irq_set;

  sync_chain #(.STAGES(SL), .INIT(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_in(ack_n), .q_out(ack_s));

  strobe_edges u_wr_edges (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n),
    .ended(wr_end), .started(wr_start), .idle(wr_idle));

  assign irq_set = ack_s & ~full_q & wr_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_end) data_q <= din;
      full_q <= full_next(full_q, wr_end, ~ack_s);
      irq_q  <= irq_next(irq_q, irq_en, wr_start, irq_set);
    end
  end

  assign dout   = data_q;
  assign full_n = ~full_q;
  assign irq    = irq_q;

  // R2
  load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> (!full_n && dout == $past(din)));
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_end |=> $stable(dout));
  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_s && !wr_end) |=> full_n);
  // R5
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && ack_s && full_n && wr_idle) |=> irq);
  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !irq);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
endmodule

// File: rtl/strobed_out_pair.sv
module strobed_out_pair
  import strobed_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cpu_din,
  input  logic              wr_a_n,
  input  logic              wr_b_n,
  input  logic              bsr_we,
  input  logic [SEL_W-1:0]  bsr_sel,
  input  logic              bsr_val,
  input  logic              ack_a_n,
  input  logic              ack_b_n,
  output logic [DATA_W-1:0] pa_dout,
  output logic [DATA_W-1:0] pb_dout,
  output logic              obf_a_n,
  output logic              obf_b_n,
  output logic              intr_a,
  output logic              intr_b
);
  logic [N_PORTS-1:0] wr_v, ack_v, full_v, irq_v, ena_v;
  logic [DATA_W-1:0]  dout_v [N_PORTS];

  assign wr_v  = {wr_b_n, wr_a_n};
  assign ack_v = {ack_b_n, ack_a_n};

  bsr_enable_bank #(.NP(N_PORTS), .SW(SEL_W)) u_enables (
    .clk(clk), .rst_n(rst_n), .cmd_we(bsr_we), .cmd_sel(bsr_sel),
    .cmd_val(bsr_val), .enables(ena_v));

  genvar p;
  generate
    for (p = 0; p < N_PORTS; p++) begin : g_port
      hs_out_port #(.W(DATA_W), .SL(SYNC_LEN)) u_port (
        .clk(clk), .rst_n(rst_n), .din(cpu_din), .wr_n(wr_v[p]),
        .ack_n(ack_v[p]), .irq_en(ena_v[p]), .dout(dout_v[p]),
        .full_n(full_v[p]), .irq(irq_v[p]));
    end
  endgenerate

  assign pa_dout = dout_v[0];
  assign pb_dout = dout_v[1];
  assign obf_a_n = full_v[0];
  assign obf_b_n = full_v[1];
  assign intr_a  = irq_v[0];
  assign intr_b  = irq_v[1];
endmodule

// File: tb/strobed_out_pair_test.sv
module strobed_out_pair_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cpu_din = 8'h00;
  logic wr_a_n = 1'b1, wr_b_n = 1'b1;
  logic bsr_we = 1'b0;
  logic [2:0] bsr_sel = 3'd0;
  logic bsr_val = 1'b0;
  logic ack_a_n = 1'b1, ack_b_n = 1'b1;
  logic [7:0] pa_dout, pb_dout;
  logic obf_a_n, obf_b_n, intr_a, intr_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobed_out_pair uut (
    .clk(clk), .rst_n(rst_n), .cpu_din(cpu_din), .wr_a_n(wr_a_n),
    .wr_b_n(wr_b_n), .bsr_we(bsr_we), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
    .ack_a_n(ack_a_n), .ack_b_n(ack_b_n), .pa_dout(pa_dout),
    .pb_dout(pb_dout), .obf_a_n(obf_a_n), .obf_b_n(obf_b_n),
    .intr_a(intr_a), .intr_b(intr_b));

  // Vector: {port (0=A,1=B), enable, data}
  localparam logic [9:0] VECS [6] = '{
    {1'b0, 1'b1, 8'hA5}, {1'b1, 1'b1, 8'h3C}, {1'b0, 1'b0, 8'hFF},
    {1'b1, 1'b0, 8'h01}, {1'b0, 1'b1, 8'h80}, {1'b1, 1'b1, 8'h7E}};

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dout_of(input bit p);
    return p ? pb_dout : pa_dout;
  endfunction
  function automatic logic obf_of(input bit p);
    return p ? obf_b_n : obf_a_n;
  endfunction
  function automatic logic intr_of(input bit p);
    return p ? intr_b : intr_a;
  endfunction

  task automatic set_wr(input bit p, input logic v);
    if (p) wr_b_n = v; else wr_a_n = v;
  endtask
  task automatic set_ack(input bit p, input logic v);
    if (p) ack_b_n = v; else ack_a_n = v;
  endtask

  task automatic do_write(input bit p, input logic [7:0] d);
    cpu_din = d;
    set_wr(p, 1'b0);
    cyc(1);
    set_wr(p, 1'b1);
    cyc(1);
    cpu_din = ~d;
  endtask

  task automatic do_bsr(input logic [2:0] s, input logic v);
    bsr_we = 1'b1; bsr_sel = s; bsr_val = v;
    cyc(1);
    bsr_we = 1'b0;
  endtask

  initial begin
    cyc(100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1 reset state
    check("R1 obf_a_n", obf_a_n, 1);
    check("R1 obf_b_n", obf_b_n, 1);
    check("R1 intr", {intr_a, intr_b}, 0);
    check("R1 dout", {pa_dout, pb_dout}, 0);
    rst_n = 1'b1;
    cyc(3);
    check("R1 enables clear, no intr", {intr_a, intr_b}, 0);

    // Table-driven write / acknowledge cycles
    foreach (VECS[i]) begin
      bit p;
      logic en;
      logic [7:0] d;
      logic [7:0] other;
      p = VECS[i][9]; en = VECS[i][8]; d = VECS[i][7:0];
      do_bsr(p ? 3'd2 : 3'd6, en);
      cyc(1);
      // R5 enabled, idle, empty -> interrupt
      check("R5 idle intr", intr_of(p), en);
      other = dout_of(~p);
      do_write(p, d);
      check("R2 data loaded", dout_of(p), d);
      check("R2 obf low", obf_of(p), 0);
      check("R6 intr cleared by write", intr_of(p), 0);
      check("R9 other data", dout_of(~p), other);
      check("R9 other obf", obf_of(~p), 1);
      set_ack(p, 1'b0);
      cyc(2);
      check("R4 obf still low at edge 2", obf_of(p), 0);
      cyc(1);
      check("R4 obf high at edge 3", obf_of(p), 1);
      check("R3 data holds under ack", dout_of(p), d);
      set_ack(p, 1'b1);
      cyc(2);
      check("R5 no intr before sync", intr_of(p), 0);
      cyc(1);
      check("R5 intr after accept", intr_of(p), en);
      check("R3 data holds after ack", dout_of(p), d);
    end

    // R7 foreign index leaves enables: clear both, poke other indexes
    do_bsr(3'd6, 1'b0);
    do_bsr(3'd2, 1'b0);
    cyc(1);
    check("R8 intr off after disable", {intr_a, intr_b}, 0);
    for (int s = 0; s < 8; s++) begin
      if (s != 6 && s != 2) do_bsr(3'(s), 1'b1);
    end
    cyc(2);
    check("R7 other index ignored", {intr_a, intr_b}, 0);
    do_bsr(3'd6, 1'b1);
    cyc(1);
    check("R7 index 6 enables A", intr_a, 1);
    check("R7 B untouched", intr_b, 0);

    // R8 clearing enable drops intr on the following edge
    do_bsr(3'd6, 1'b0);
    check("R8 intr holds one edge", intr_a, 1);
    cyc(1);
    check("R8 intr low", intr_a, 0);

    // R4 write wins over a held acknowledge
    set_ack(1, 1'b0);
    cyc(4);
    do_write(1, 8'h5A);
    check("R4 write wins", obf_b_n, 0);
    check("R2 data under held ack", pb_dout, 8'h5A);
    cyc(1);
    check("R4 empties next cycle", obf_b_n, 1);
    set_ack(1, 1'b1);
    cyc(5);
    check("R3 data stable", pb_dout, 8'h5A);

    // R6 strobe fall clears intr while strobe is held low
    do_bsr(3'd2, 1'b1);
    cyc(1);
    check("R5 B intr", intr_b, 1);
    wr_b_n = 1'b0;
    cyc(1);
    check("R6 cleared on fall", intr_b, 0);
    cyc(3);
    check("R6 stays low while strobe low", intr_b, 0);
    cpu_din = 8'hC3;
    wr_b_n = 1'b1;
    cyc(1);
    check("R2 long strobe load", pb_dout, 8'hC3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule